// File: doc/BRIEF.md
# Dual-Mode Serial Shifter and Pulse Down-Counter

This block holds one small data register that serves two purposes, chosen by a mode input. In shift mode the register moves left by one place at the end of every instruction cycle. The serial input enters at the low end, and the top bit can be routed to the serial data output, so the register acts as the data stage of a clocked three-wire serial link. In count mode the same register is a down-counter. It steps down by one for every qualified falling edge on the serial input, so a processor can count slow external events without polling.

An internal phase counter divides the system clock into instruction cycles. It produces a one-clock end-of-cycle strobe and a cycle-clock level that is high during the first half of each cycle. The serial input passes through a synchronizer before it is used. The serial clock output is gated by a one-bit clock-permit latch.

A single exchange strobe loads the register from the accumulator bus and the latch from the carry input in the same clock edge. The accumulator reads the contents before the exchange from `sio_q`.

Top module: `sio_shift_counter`

## Requirements
- R1: While reset is low the register reads 0, `so` is 0 and the clock-permit latch is 1. As a result, `sk` follows the cycle clock once shift mode runs.
- R2: With `mode_cnt`=0, the register shifts left by one place at the end of each instruction cycle. The synchronized serial input enters bit 0, and bit W-1 is dropped.
- R3: In shift mode with `so_en`=1, `so` equals register bit W-1. With `so_en`=0, `so` is 0 and shifting continues.
- R4: In shift mode, `sk` equals the clock-permit latch ANDed with the cycle clock. The cycle clock is high for phases 0 to CYC_DIV/2-1 and low for the rest of the cycle.
- R5: With `mode_cnt`=1, the register decrements by one once per qualified low pulse on `si`. The decrement happens at the end of the instruction cycle in which the input has been seen low for MIN_LOW cycles. The register does not shift in this mode.
- R6: A low phase on `si` shorter than MIN_LOW instruction cycles changes nothing. A low level that was not preceded by a high sample, including the first low level after reset, is not counted.
- R7: A decrement from 0 gives 2^W-1.
- R8: In count mode `so` equals `so_en` and `sk` equals the clock-permit latch level.
- R9: A high `xchg` at a clock edge loads `acc_in` into the register and `carry_in` into the clock-permit latch at that edge.
- R10: When an exchange coincides with a shift or a decrement, the exchange wins and the register takes `acc_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| mode_cnt | input | 1 | 0 selects shift mode, 1 selects count mode |
| so_en | input | 1 | Serial-output enable (shift) or output level (count) |
| si | input | 1 | Serial data / event input, asynchronous |
| xchg | input | 1 | Exchange strobe, one clock wide |
| acc_in | input | W | Accumulator value loaded on exchange |
| carry_in | input | 1 | Carry copied into the clock-permit latch on exchange |
| sio_q | output | W | Current register contents |
| so | output | 1 | Serial data output |
| sk | output | 1 | Serial clock output |

## Verification
An exchange shows on `sio_q` one clock after the strobe. A shift or a decrement shows one clock after the end-of-cycle strobe, that is, on the fourth clock edge of a cycle for the default divide-by-four. The serial input reaches the register two clocks after it is sampled, so the bench sets `si` at the falling edge that opens each instruction cycle and holds it for the whole cycle. It then compares the register and `so` at the falling edge after the cycle's last rising edge. The value of `sk` is checked at the falling edges after phases 1 and 2, where the cycle clock is known to be high and low respectively. A count therefore lands at the end of the second low cycle of a pulse.

// File: rtl/sio_pkg.sv
package sio_pkg;

  typedef enum logic {
    MODE_SHIFT = 1'b0,
    MODE_COUNT = 1'b1
  } sio_mode_e;

endpackage

// File: rtl/sio_cycle_timer.sv
module sio_cycle_timer #(
  parameter int CYC_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick,
  output logic cyc_clk
);
  localparam int PW = (CYC_DIV > 2) ? $clog2(CYC_DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(CYC_DIV - 1);
  localparam logic [PW-1:0] HALF = PW'(CYC_DIV / 2);

  logic [PW-1:0] phase_q, phase_d;

  always_comb begin
    if (phase_q == LAST) phase_d = '0;
    else                 phase_d = phase_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_d;
  end

  assign tick    = (phase_q == LAST);
  assign cyc_clk = (phase_q < HALF);
endmodule

// File: rtl/sio_si_qualifier.sv
module sio_si_qualifier #(
  parameter int SYNC_STAGES = 2,
  parameter int MIN_LOW     = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic si,
  input  logic tick,
  output logic si_s,
  output logic fall_ev
);
  localparam int LCW = $clog2(MIN_LOW + 1);
  localparam logic [LCW-1:0] LC_LAST = LCW'(MIN_LOW - 1);
  localparam logic [LCW-1:0] LC_SAT  = LCW'(MIN_LOW);

  logic [SYNC_STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q[0] <= 1'b0;
    else        sync_q[0] <= si;
  end

  for (genvar g = 1; g < SYNC_STAGES; g++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q[g] <= 1'b0;
      else        sync_q[g] <= sync_q[g-1];
    end
  end

  assign si_s = sync_q[SYNC_STAGES-1];

  logic [LCW-1:0] low_q, low_d;
  logic           armed_q, armed_d;
  logic           ev;

  always_comb begin
    low_d   = low_q;
    armed_d = armed_q;
    ev      = 1'b0;
    if (tick) begin
      if (si_s) begin
        low_d   = '0;
        armed_d = 1'b1;
      end else begin
        if (low_q != LC_SAT) low_d = low_q + 1'b1;
        if (armed_q && (low_q == LC_LAST)) begin
          ev      = 1'b1;
          armed_d = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_q   <= '0;
      armed_q <= 1'b0;
    end else if (tick) begin
      low_q   <= low_d;
      armed_q <= armed_d;
    end
  end

  assign fall_ev = ev;
endmodule

// File: rtl/sio_data_reg.sv
module sio_data_reg #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         count_mode,
  input  logic         tick,
  input  logic         dec_ev,
  input  logic         shift_in,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] q
);
  logic [W-1:0] q_d;
  logic         q_en;

  always_comb begin
    q_d  = q;
    q_en = 1'b0;
    if (load) begin
      q_d  = load_val;
      q_en = 1'b1;
    end else if (count_mode) begin
      if (dec_ev) begin
        q_d  = q - 1'b1;
        q_en = 1'b1;
      end
    end else if (tick) begin
      q_d  = {q[W-2:0], shift_in};
      q_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (q_en) q <= q_d;
  end
endmodule

// File: rtl/sio_shift_counter.sv
module sio_shift_counter
  import sio_pkg::*;
#(
  parameter int W           = 4,
  parameter int CYC_DIV     = 4,
  parameter int MIN_LOW     = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         mode_cnt,
  input  logic         so_en,
  input  logic         si,
  input  logic         xchg,
  input  logic [W-1:0] acc_in,
  input  logic         carry_in,
  output logic [W-1:0] sio_q,
  output logic         so,
  output logic         sk
);
  logic      tick, cyc_clk, si_s, cnt_ev;
  logic      skl_q, skl_d;
  sio_mode_e mode;

  assign mode = sio_mode_e'(mode_cnt);

  sio_cycle_timer #(.CYC_DIV(CYC_DIV)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cyc_clk(cyc_clk)
  );

  sio_si_qualifier #(.SYNC_STAGES(SYNC_STAGES), .MIN_LOW(MIN_LOW)) u_qual (
    .clk(clk), .rst_n(rst_n), .si(si), .tick(tick),
    .si_s(si_s), .fall_ev(cnt_ev)
  );

  sio_data_reg #(.W(W)) u_reg (
    .clk(clk), .rst_n(rst_n), .count_mode(mode == MODE_COUNT),
    .tick(tick), .dec_ev(cnt_ev), .shift_in(si_s),
    .load(xchg), .load_val(acc_in), .q(sio_q)
  );

  always_comb begin
    skl_d = skl_q;
    if (xchg) skl_d = carry_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) skl_q <= 1'b1;
    else        skl_q <= skl_d;
  end

  always_comb begin
    unique case (mode)
      MODE_COUNT: begin
        so = so_en;
        sk = skl_q;
      end
      default: begin
        so = so_en & sio_q[W-1];
        sk = skl_q & cyc_clk;
      end
    endcase
  end
endmodule

// File: rtl/sio_shift_counter_chk.sv
module sio_shift_counter_chk #(
  parameter int W = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic         mode_cnt,
  input logic         xchg,
  input logic [W-1:0] acc_in,
  input logic         carry_in,
  input logic         tick,
  input logic         cnt_ev,
  input logic         si_s,
  input logic         skl_q,
  input logic [W-1:0] sio_q
);
  AST_XCHG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    xchg |=> (sio_q == $past(acc_in)) && (skl_q == $past(carry_in))); // R9

  AST_SKL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !xchg |=> $stable(skl_q)); // R9

  AST_SHIFT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_cnt && tick && !xchg) |=> sio_q == {$past(sio_q[W-2:0]), $past(si_s)}); // R2

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_cnt && cnt_ev && !xchg) |=> sio_q == $past(sio_q) - 1'b1); // R5

  AST_COUNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_cnt && !cnt_ev && !xchg) |=> $stable(sio_q)); // R6

  AST_EVENT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_ev |=> !cnt_ev); // R5

  AST_EVENT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_ev |-> (!si_s && tick)); // R6
endmodule

bind sio_shift_counter sio_shift_counter_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_cnt(mode_cnt), .xchg(xchg),
  .acc_in(acc_in), .carry_in(carry_in), .tick(tick), .cnt_ev(cnt_ev),
  .si_s(si_s), .skl_q(skl_q), .sio_q(sio_q)
);

// File: tb/sio_shift_counter_test.sv
module sio_shift_counter_test;
  localparam int CLK_PERIOD = 10;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst_n, mode_cnt, so_en, si, xchg, carry_in;
  logic [W-1:0] acc_in;
  logic [W-1:0] sio_q;
  logic         so, sk;

  int checks = 0;
  int errors = 0;

  logic [W-1:0] exp_q;
  bit           exp_skl;
  bit           armed;
  int           lowcnt;

  always #(CLK_PERIOD/2) clk = ~clk;

  sio_shift_counter uut (
    .clk(clk), .rst_n(rst_n), .mode_cnt(mode_cnt), .so_en(so_en), .si(si),
    .xchg(xchg), .acc_in(acc_in), .carry_in(carry_in),
    .sio_q(sio_q), .so(so), .sk(sk)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One instruction cycle (4 clocks) from the falling edge that opens it.
  task automatic cycle(input bit m, input bit en3, input bit sbit,
                       input bit early_x, input bit late_x,
                       input logic [W-1:0] xv, input bit xc);
    bit ev;
    mode_cnt = m; so_en = en3; si = sbit;
    acc_in = xv; carry_in = xc; xchg = early_x;
    @(posedge clk); @(negedge clk);
    xchg = 1'b0;
    if (early_x) begin
      exp_q = xv; exp_skl = xc;
      chk(sio_q == exp_q, "R9 exchange load", sio_q, exp_q);
    end
    chk(sk == exp_skl, m ? "R8 sk level" : "R4 sk high phase", sk, exp_skl);
    @(posedge clk); @(negedge clk);
    chk(sk == (m ? exp_skl : 1'b0), m ? "R8 sk level" : "R4 sk low phase",
        sk, m ? exp_skl : 1'b0);
    @(posedge clk); @(negedge clk);
    xchg = late_x;
    @(posedge clk); @(negedge clk);
    xchg = 1'b0;
    ev = 1'b0;
    if (sbit) begin
      lowcnt = 0; armed = 1'b1;
    end else begin
      ev = armed && (lowcnt == 1);
      if (ev) armed = 1'b0;
      if (lowcnt < 2) lowcnt++;
    end
    if (late_x) begin
      exp_q = xv; exp_skl = xc;
    end else if (m) begin
      if (ev) exp_q = exp_q - 1'b1;
    end else begin
      exp_q = {exp_q[W-2:0], sbit};
    end
    chk(sio_q == exp_q,
        late_x ? "R10 exchange wins" : (m ? "R5/R7 count" : "R2 shift"),
        sio_q, exp_q);
    if (m) chk(so == en3, "R8 so level", so, en3);
    else   chk(so == (en3 & exp_q[W-1]), "R3 serial out", so, en3 & exp_q[W-1]);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; mode_cnt = 1'b0; so_en = 1'b1; si = 1'b1;
    xchg = 1'b0; acc_in = '0; carry_in = 1'b0;
    repeat (3) @(negedge clk);
    exp_q = '0; exp_skl = 1'b1; armed = 1'b0; lowcnt = 0;
    chk(sio_q == 0, "R1 reset register", sio_q, 0);
    chk(so == 1'b0, "R1 reset so", so, 0);
    chk(sk == 1'b1, "R1 reset sk", sk, 1);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    // R2 R3 R4: every start value, both output enables, then a stream of bits
    for (int v = 0; v < 16; v++) begin
      for (int e = 0; e < 2; e++) begin
        cycle(1'b0, e[0], ~v[0], 1'b1, 1'b0, v[W-1:0], 1'b1);
        for (int k = 0; k < 4; k++)
          cycle(1'b0, e[0], v[k] ^ e[0], 1'b0, 1'b0, '0, 1'b0);
      end
    end
    // R4: permit latch cleared by exchange, sk stays low
    cycle(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 4'hA, 1'b0);
    cycle(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, '0, 1'b0);
    // R5 R7 R8: one qualified pulse from every start value, including 0
    cycle(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, '0, 1'b0);
    for (int v = 0; v < 16; v++) begin
      cycle(1'b1, v[1], 1'b0, 1'b1, 1'b0, v[W-1:0], v[0]);
      cycle(1'b1, v[1], 1'b0, 1'b0, 1'b0, '0, 1'b0);
      cycle(1'b1, v[2], 1'b0, 1'b0, 1'b0, '0, 1'b0);
      cycle(1'b1, v[2], 1'b1, 1'b0, 1'b0, '0, 1'b0);
    end
    // R6: a one-cycle low pulse is ignored
    for (int k = 0; k < 3; k++) begin
      cycle(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, '0, 1'b0);
      cycle(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, '0, 1'b0);
    end
    // R10: exchange in the same clock as a decrement and as a shift
    cycle(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, '0, 1'b0);
    cycle(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 4'h9, 1'b1);
    cycle(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 4'h6, 1'b0);
    cycle(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 4'h3, 1'b1);
    // R6: after reset a low input without a prior high is not counted
    do_reset();
    cycle(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 4'h7, 1'b1);
    cycle(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, '0, 1'b0);
    cycle(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, '0, 1'b0);
    chk(sio_q == 4'h7, "R6 no count without prior high", sio_q, 7);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule